// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Configurable Pin Interrupts

This block is a general-purpose I/O port of eight pins that sits on a simple 32-bit register bus. Each pin can be an input or an output. Software reads and writes pin values through a data window, and the word address within that window chooses which pins a transfer touches. Pin inputs pass through a two-flop synchronizer before they are read back or used for interrupt detection.

Each pin has its own interrupt mode. Level mode shows a live high or low condition. Edge mode catches a rising edge, a falling edge, or both, and holds a latched flag until software clears it. A raw status word, a status word gated by the per-pin enables, a write-one-to-clear register and one combined interrupt line complete the block.

The bus side is a small phase tracker with three named states. **IDLE** moves to **SETUP** when select rises without enable. **SETUP** moves to **ACCESS** when enable joins select, returns to **IDLE** if select drops, and otherwise stays in SETUP. **ACCESS** moves to **SETUP** when a new transfer begins right away (select high, enable low), and otherwise moves to **IDLE**. A register write commits only on the SETUP-to-ACCESS transition.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), `pin_out` = 0, `irq` = 0, and every configuration and status register reads 0.
- R2: The direction register at byte offset 0x400 reads back as written. Bit i = 1 makes pin i an output, and `pin_oe` equals this register.
- R3: Offsets below 0x400 form the data window, and `paddr[9:2]` is a per-pin mask. A write changes only the output latches of masked pins. A read returns 0 for unmasked pins, the output latch for masked output pins, and the synchronized input for masked input pins.
- R4: A data write has no effect on the output latch of a pin whose direction bit is 0. An input pin reads the value of `pin_in` two clock edges after it changes.
- R5: Sense register (0x404) bit = 1 selects level mode. The event register (0x40C) bit then selects active high (1) or active low (0). Level status follows the synchronized input, is never latched, and is not affected by a clear.
- R6: Sense bit = 0 selects edge mode. With both-edges bit 0, event bit 1 latches the raw status on a rising edge and event bit 0 latches it on a falling edge. The latched bit stays set after the input returns.
- R7: The both-edges register (0x408) bit = 1 latches status on either edge and ignores the event bit.
- R8: Raw status reads at 0x414. Masked status at 0x418 equals raw status AND the enable register (0x410). `irq` is the OR of the masked bits.
- R9: Writing 1 to bit i of the clear register (0x41C) clears pin i's latched edge status, and writing 0 leaves it unchanged. An edge detected in the same cycle as the clear keeps the bit set.
- R10: Reads of unimplemented offsets, including the clear register and offsets at 0x420 and above, return 0.
- R11: A write takes effect only in an access cycle that follows a setup cycle. Select and enable raised together from idle write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational during select) |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output latch values |
| pin_oe | output | 8 | Output enables (direction register) |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check several rules on every cycle. A detected edge sets the latch, a clear without a concurrent edge empties it, and level mode never holds a latch. Data writes never disturb input-pin latches, `pin_oe` follows a direction write, `irq` never rises with all enables off, and the bus logic produces a single write strobe per transfer. The bench scenarios cover the rest: exact readback values, the address-mask selection, each edge polarity, the same-cycle edge-and-clear race, and the refusal of malformed transfers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_SETUP  = 2'd1,
        BUS_ACCESS = 2'd2
    } bus_phase_e;

    // word indices (byte offset >> 2)
    localparam int unsigned W_DIR   = 'h100;
    localparam int unsigned W_SENSE = 'h101;
    localparam int unsigned W_BOTH  = 'h102;
    localparam int unsigned W_EVT   = 'h103;
    localparam int unsigned W_IE    = 'h104;
    localparam int unsigned W_RAW   = 'h105;
    localparam int unsigned W_MIS   = 'h106;
    localparam int unsigned W_CLR   = 'h107;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_en,
    output logic rd_en
);
    bus_phase_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE:   if (psel && !penable) state_nx = BUS_SETUP;
            BUS_SETUP:  if (psel && penable)  state_nx = BUS_ACCESS;
                        else if (!psel)       state_nx = BUS_IDLE;
            BUS_ACCESS: if (psel && !penable) state_nx = BUS_SETUP;
                        else                  state_nx = BUS_IDLE;
            default:    state_nx = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_en = (state == BUS_SETUP) && psel && penable && pwrite;
        rd_en = psel && !pwrite;
    end

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R11
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic sense,
    input  logic both,
    input  logic evt,
    input  logic clr,
    output logic raw
);
    logic prev, latch, rise, fall, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= smp;
    end

    always_comb begin
        rise = smp & ~prev;
        fall = ~smp & prev;
        hit  = both ? (rise | fall) : (evt ? rise : fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     latch <= 1'b0;
        else if (sense) latch <= 1'b0;
        else if (hit)   latch <= 1'b1;
        else if (clr)   latch <= 1'b0;
    end

    assign raw = sense ? (evt ? smp : ~smp) : latch;

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense && hit) |=> latch); // R6
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense && clr && !hit) |=> !latch); // R9
    AST_LEVEL_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        sense |=> !latch); // R5
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic          irq
);
    localparam int WORD_W = AW - 2;

    logic            wr_en, rd_en, in_data;
    logic [WORD_W-1:0] word;
    logic [NPIN-1:0] mask, wval, smp, clr;
    logic [NPIN-1:0] dir, sense, both, evt, ie, dout, raw, mis, rd_val;
    logic            unused_bits;

    assign word    = paddr[AW-1:2];
    assign in_data = (paddr[AW-1:10] == '0);
    assign mask    = paddr[NPIN+1:2];
    assign wval    = pwdata[NPIN-1:0];
    assign unused_bits = ^{pwdata[DW-1:NPIN], paddr[1:0]};

    gpio_bus_fsm u_bus (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .wr_en(wr_en), .rd_en(rd_en)
    );

    gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp)
    );

    assign clr = (wr_en && word == WORD_W'(W_CLR)) ? wval : '0;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpio_irq_cell u_cell (
            .clk(clk), .rst_n(rst_n), .smp(smp[i]), .sense(sense[i]),
            .both(both[i]), .evt(evt[i]), .clr(clr[i]), .raw(raw[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir <= '0; sense <= '0; both <= '0; evt <= '0; ie <= '0; dout <= '0;
        end else if (wr_en) begin
            if (in_data) begin
                dout <= (dout & ~(mask & dir)) | (wval & mask & dir);
            end else begin
                case (word)
                    WORD_W'(W_DIR):   dir   <= wval;
                    WORD_W'(W_SENSE): sense <= wval;
                    WORD_W'(W_BOTH):  both  <= wval;
                    WORD_W'(W_EVT):   evt   <= wval;
                    WORD_W'(W_IE):    ie    <= wval;
                    default: ;
                endcase
            end
        end
    end

    assign mis = raw & ie;

    always_comb begin
        rd_val = '0;
        if (rd_en) begin
            if (in_data) begin
                rd_val = mask & ((dir & dout) | (~dir & smp));
            end else begin
                case (word)
                    WORD_W'(W_DIR):   rd_val = dir;
                    WORD_W'(W_SENSE): rd_val = sense;
                    WORD_W'(W_BOTH):  rd_val = both;
                    WORD_W'(W_EVT):   rd_val = evt;
                    WORD_W'(W_IE):    rd_val = ie;
                    WORD_W'(W_RAW):   rd_val = raw;
                    WORD_W'(W_MIS):   rd_val = mis;
                    default:          rd_val = '0;
                endcase
            end
        end
    end

    assign prdata  = {{(DW-NPIN){1'b0}}, rd_val};
    assign pin_out = dout;
    assign pin_oe  = dir;
    assign irq     = |mis;

    AST_INPUT_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((dout ^ $past(dout)) & ~$past(dir)) == '0)); // R4
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie != '0)); // R8
    AST_OE_FOLLOWS_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == WORD_W'(W_DIR)) |=> (pin_oe == $past(wval))); // R2
endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_irq_port uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {addr[11:0], wdata[7:0], expected[7:0], req[3:0], pad[3:0]}
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {12'h400, 8'hA5, 8'hA5, 4'd2, 4'd0},  // R2 direction readback
        {12'h404, 8'h5A, 8'h5A, 4'd5, 4'd0},  // R5 sense readback
        {12'h408, 8'hC3, 8'hC3, 4'd7, 4'd0},  // R7 both-edges readback
        {12'h40C, 8'h3C, 8'h3C, 4'd6, 4'd0},  // R6 event readback
        {12'h410, 8'h0F, 8'h0F, 4'd8, 4'd0},  // R8 enable readback
        {12'h420, 8'hFF, 8'h00, 4'd10, 4'd0}, // R10 unimplemented
        {12'h41C, 8'hFF, 8'h00, 4'd10, 4'd0}, // R10 clear reads zero
        {12'h800, 8'hFF, 8'h00, 4'd10, 4'd0}, // R10 high offset
        {12'h400, 8'h00, 8'h00, 4'd2, 4'd0},
        {12'h404, 8'h00, 8'h00, 4'd5, 4'd0},
        {12'h408, 8'h00, 8'h00, 4'd7, 4'd0},
        {12'h40C, 8'h00, 8'h00, 4'd6, 4'd0},
        {12'h410, 8'h00, 8'h00, 4'd8, 4'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", {24'd0, pin_oe}, 32'h0);
        check("R1 out", {24'd0, pin_out}, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        rd(12'h400, r); check("R1 dir", r, 32'h0);
        rd(12'h414, r); check("R1 raw", r, 32'h0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k][35:24], {24'd0, VEC[k][23:16]});
            rd(VEC[k][35:24], r);
            check($sformatf("R%0d table %0d", VEC[k][7:4], k), r, {24'd0, VEC[k][15:8]});
        end
        wr(12'h41C, 32'hFF);

        // R2 direction drives pin_oe
        wr(12'h400, 32'h81);
        check("R2 oe", {24'd0, pin_oe}, 32'h81);

        // R3 / R4 data window
        wr(12'h400, 32'h0F);
        wr(12'h3FC, 32'hFF);
        check("R4 input latches untouched", {24'd0, pin_out}, 32'h0F);
        wr(12'h00C, 32'h00);
        check("R3 masked write", {24'd0, pin_out}, 32'h0C);
        pin_in = 8'hA0;
        settle();
        rd(12'h3FC, r); check("R3 R4 full read", r, 32'hAC);
        rd(12'h0C0, r); check("R3 masked read", r, 32'h20);
        wr(12'h400, 32'h00);
        pin_in = 8'h00;
        settle();
        wr(12'h41C, 32'hFF);

        // R5 level mode
        wr(12'h404, 32'h01); wr(12'h40C, 32'h01); wr(12'h410, 32'h01);
        pin_in[0] = 1; settle();
        rd(12'h414, r); check("R5 level high raw", r, 32'h01);
        check("R5 irq", {31'd0, irq}, 32'h1);
        wr(12'h41C, 32'h01);
        rd(12'h414, r); check("R5 clear ignored", r, 32'h01);
        pin_in[0] = 0; settle();
        rd(12'h414, r); check("R5 follows input", r, 32'h00);
        check("R5 irq low", {31'd0, irq}, 32'h0);
        wr(12'h40C, 32'h00);
        rd(12'h414, r); check("R5 active low", r, 32'h01);
        wr(12'h404, 32'h00); wr(12'h410, 32'h00);
        wr(12'h41C, 32'hFF);

        // R6 single edge
        wr(12'h40C, 32'h02);
        pin_in[1] = 1; settle();
        rd(12'h414, r); check("R6 rising latched", r, 32'h02);
        pin_in[1] = 0; settle();
        rd(12'h414, r); check("R6 held after return", r, 32'h02);
        wr(12'h41C, 32'h00);
        rd(12'h414, r); check("R9 zero write no effect", r, 32'h02);
        wr(12'h41C, 32'h02);
        rd(12'h414, r); check("R9 clear", r, 32'h00);
        pin_in[2] = 1; settle();
        rd(12'h414, r); check("R6 rise ignored in falling mode", r, 32'h00);
        pin_in[2] = 0; settle();
        rd(12'h414, r); check("R6 falling latched", r, 32'h04);
        wr(12'h41C, 32'hFF);

        // R7 both edges, event bit 0
        wr(12'h408, 32'h08);
        pin_in[3] = 1; settle();
        rd(12'h414, r); check("R7 rise", r, 32'h08);
        wr(12'h41C, 32'h08);
        pin_in[3] = 0; settle();
        rd(12'h414, r); check("R7 fall", r, 32'h08);
        wr(12'h41C, 32'h08);

        // R8 masking
        wr(12'h410, 32'h04);
        pin_in[2] = 1; settle(); pin_in[2] = 0; pin_in[1] = 1; settle();
        rd(12'h414, r); check("R8 raw", r, 32'h06);
        rd(12'h418, r); check("R8 masked", r, 32'h04);
        check("R8 irq", {31'd0, irq}, 32'h1);
        wr(12'h41C, 32'h06);
        check("R8 irq cleared", {31'd0, irq}, 32'h0);
        rd(12'h418, r); check("R8 masked cleared", r, 32'h00);

        // R9 edge beats same-cycle clear
        pin_in[3] = 1; settle();
        @(negedge clk); pin_in[3] = 0;
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h41C; pwdata = 32'h08;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        rd(12'h414, r); check("R9 edge wins", r, 32'h08);
        wr(12'h41C, 32'h08);
        rd(12'h414, r); check("R9 later clear", r, 32'h00);

        // R11 no setup phase: nothing written
        @(negedge clk); psel = 1; penable = 1; pwrite = 1; paddr = 12'h400; pwdata = 32'hFF;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        check("R11 oe unchanged", {24'd0, pin_oe}, 32'h00);
        rd(12'h400, r); check("R11 dir unchanged", r, 32'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule